// File: doc/BRIEF.md
# Pipelined Complex Matrix Multiplier

The block computes the product C = A x B of two 16 x 16 matrices whose elements are complex numbers with 16-bit signed real and imaginary parts. It does not receive operands as pushed data. Instead it acts as the master on two external synchronous block-RAM read ports, one holding the rows of A and one holding the columns of B. Each memory word carries a whole row or a whole column, so a single read delivers every element that one dot product needs.

A one-cycle `start` pulse launches one matrix operation. The block then issues one column read every clock and one row read at the start of each row. All 16 complex products of a dot product are formed in parallel and summed in a registered adder tree. After a fixed pipeline delay, one result element per clock goes out on a write port with an address and a write enable. A full product takes 256 issue cycles plus the pipeline drain. A one-cycle `done` pulse marks the end of the operation.

Top module: `cplx_matmul`

## Requirements
- R1: Each written element (i,j) equals the sum over k of A[i][k]*B[k][j], where each complex product is (ar*br - ai*bi) + j(ar*bi + ai*br), computed exactly in two's complement.
- R2: Operand word i of the A port holds row i, and word j of the B port holds column j, with element k = B[k][j]. Element k sits at bits [32k+15:32k] (real) and [32k+31:32k+16] (imaginary). The result word carries the real sum in bits [37:0] and the imaginary sum in bits [75:38].
- R3: Result components are 38 bits wide and stay exact when every operand part is -32768 or 32767, with no overflow or wrap.
- R4: One operation writes exactly 256 results, on consecutive clocks, in row-major order at address i*16+j, starting at address 0.
- R5: The first `r_we` comes exactly 13 clock cycles after the cycle of the first operand read of that operation.
- R6: `b_en` is high in every issue cycle, and `b_addr` steps 0..15 and then repeats. `a_en` is high only in issue cycles where `b_addr` is 0, with `a_addr` equal to the row index, which gives 16 row reads and 256 column reads per operation. Read data is taken one cycle after the enable.
- R7: A `start` pulse that arrives while an operation is in progress is ignored. It causes no extra reads, writes or `done` pulses.
- R8: `done` is high for exactly one cycle, in the cycle after the 256th write. A `start` pulse in that cycle is accepted and begins a new operation.
- R9: During and after reset, until a `start` is accepted, `a_en`, `b_en`, `r_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches an operation when idle |
| done | output | 1 | One-cycle pulse after the last result is written |
| a_en | output | 1 | Read enable of the A row memory |
| a_addr | output | 4 | Row index read from the A memory |
| a_rdata | input | 512 | A row word, returned one cycle after `a_en` |
| b_en | output | 1 | Read enable of the B column memory |
| b_addr | output | 4 | Column index read from the B memory |
| b_rdata | input | 512 | B column word, returned one cycle after `b_en` |
| r_we | output | 1 | Result write enable |
| r_addr | output | 8 | Result address i*16+j |
| r_data | output | 76 | Result element, imaginary sum over real sum |

## Verification
The assertions assume that both memories return the addressed word on the clock after the enable, that `start` is a single-cycle pulse, and that the matrix dimension is a power of two so the adder tree halves cleanly. The bench memory model is a registered array read on the enable, and the bench drives `start` for exactly one clock, away from the active edge. The only `start` pulses that fall outside the idle state are the deliberate ones sent in the middle of a run and in the `done` cycle. The operand sets span small mixed-sign values, pseudo-random full-range values, and two all-extreme patterns that push the real or the imaginary sum to its largest magnitude.

// File: rtl/cmm_pkg.sv
package cmm_pkg;

  // Controller phases: waiting, issuing operand reads, emptying the pipeline.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } ctrl_st_t;

endpackage

// File: rtl/cmm_delay.sv
module cmm_delay #(
  parameter int W      = 8,
  parameter int D      = 4,
  parameter bit RST_EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] sr [D];

  always_ff @(posedge clk) begin
    if (RST_EN && rst) begin
      for (int k = 0; k < D; k++) sr[k] <= '0;
    end else begin
      sr[0] <= din;
      for (int k = 1; k < D; k++) sr[k] <= sr[k-1];
    end
  end

  assign dout = sr[D-1];

endmodule

// File: rtl/cmm_ctrl.sv
module cmm_ctrl
  import cmm_pkg::*;
#(
  parameter int N  = 16,
  localparam int IW = $clog2(N),
  localparam int AW = 2 * IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          last_out,
  output logic          a_en,
  output logic [IW-1:0] a_addr,
  output logic          b_en,
  output logic [IW-1:0] b_addr,
  output logic          issue,
  output logic [AW-1:0] issue_idx,
  output logic          done
);

  localparam logic [IW-1:0] LAST_I = IW'(N - 1);

  ctrl_st_t      st;
  logic [IW-1:0] row_q;
  logic [IW-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st    <= ST_RUN;
            row_q <= '0;
            col_q <= '0;
          end
        end
        ST_RUN: begin
          col_q <= col_q + 1'b1;
          if (col_q == LAST_I) begin
            row_q <= row_q + 1'b1;
            if (row_q == LAST_I) st <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (last_out) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign issue     = (st == ST_RUN);
  assign b_en      = issue;
  assign b_addr    = col_q;
  assign a_en      = issue && (col_q == '0);
  assign a_addr    = row_q;
  assign issue_idx = {row_q, col_q};

  // R6: column reads advance by one per clock inside a row sweep
  p_bcol_step_r6: assert property (@(posedge clk) disable iff (rst)
    (b_en && b_addr != '0) |-> ($past(b_en) && b_addr == $past(b_addr) + 1'b1));

  // R7: a start while issuing does not restart the index sequence
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (issue && start && issue_idx != '1) |=> (issue && issue_idx == $past(issue_idx) + 1'b1));

endmodule

// File: rtl/cmm_cmul_lane.sv
module cmm_cmul_lane #(
  parameter int DW    = 16,
  parameter int ACC_W = 38
) (
  input  logic                    clk,
  input  logic signed [DW-1:0]    a_re,
  input  logic signed [DW-1:0]    a_im,
  input  logic signed [DW-1:0]    b_re,
  input  logic signed [DW-1:0]    b_im,
  output logic signed [ACC_W-1:0] p_re,
  output logic signed [ACC_W-1:0] p_im
);

  localparam int PW  = 2 * DW;
  localparam int EXT = ACC_W - PW;

  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [ACC_W-1:0] x_rr, x_ii, x_ri, x_ir;

  // Stage 1: four full-precision partial products.
  always_ff @(posedge clk) begin
    m_rr <= a_re * b_re;
    m_ii <= a_im * b_im;
    m_ri <= a_re * b_im;
    m_ir <= a_im * b_re;
  end

  assign x_rr = {{EXT{m_rr[PW-1]}}, m_rr};
  assign x_ii = {{EXT{m_ii[PW-1]}}, m_ii};
  assign x_ri = {{EXT{m_ri[PW-1]}}, m_ri};
  assign x_ir = {{EXT{m_ir[PW-1]}}, m_ir};

  // Stage 2: complex recombination at accumulator width.
  always_ff @(posedge clk) begin
    p_re <= x_rr - x_ii;
    p_im <= x_ri + x_ir;
  end

endmodule

// File: rtl/cmm_sum_tree.sv
module cmm_sum_tree #(
  parameter int N  = 16,
  parameter int W  = 38,
  localparam int LV = $clog2(N)
) (
  input  logic                clk,
  input  logic signed [W-1:0] leaf [N],
  output logic signed [W-1:0] total
);

  for (genvar l = 0; l < LV; l++) begin : g_lv
    localparam int CNT = N >> (l + 1);
    logic signed [W-1:0] node [CNT];
    if (l == 0) begin : g_first
      always_ff @(posedge clk) begin
        for (int e = 0; e < CNT; e++) node[e] <= leaf[2*e] + leaf[2*e+1];
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        for (int e = 0; e < CNT; e++)
          node[e] <= g_lv[l-1].node[2*e] + g_lv[l-1].node[2*e+1];
      end
    end
  end

  assign total = g_lv[LV-1].node[0];

endmodule

// File: rtl/cplx_matmul.sv
module cplx_matmul #(
  parameter int N       = 16,
  parameter int DW      = 16,
  parameter int ACC_W   = 38,
  parameter int LATENCY = 13,
  localparam int IW     = $clog2(N),
  localparam int AW     = 2 * IW,
  localparam int EW     = 2 * DW,
  localparam int WORDW  = N * EW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               done,
  output logic               a_en,
  output logic [IW-1:0]      a_addr,
  input  logic [WORDW-1:0]   a_rdata,
  output logic               b_en,
  output logic [IW-1:0]      b_addr,
  input  logic [WORDW-1:0]   b_rdata,
  output logic               r_we,
  output logic [AW-1:0]      r_addr,
  output logic [2*ACC_W-1:0] r_data
);

  localparam int LV   = $clog2(N);
  // Registered stages before the delay line: products, recombine, tree levels.
  localparam int DPAD = LATENCY - 3 - LV;

  logic          issue;
  logic [AW-1:0] issue_idx;
  logic          last_out;
  logic          issue_q;
  logic          row_new_q;
  logic [WORDW-1:0] a_hold;
  logic [WORDW-1:0] a_cur;

  cmm_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .last_out  (last_out),
    .a_en      (a_en),
    .a_addr    (a_addr),
    .b_en      (b_en),
    .b_addr    (b_addr),
    .issue     (issue),
    .issue_idx (issue_idx),
    .done      (done)
  );

  // Read data returns one cycle after the enable; track which cycles carry it.
  always_ff @(posedge clk) begin
    if (rst) begin
      issue_q   <= 1'b0;
      row_new_q <= 1'b0;
    end else begin
      issue_q   <= issue;
      row_new_q <= a_en;
    end
  end

  // The row word is used straight from memory on its first column, then held.
  assign a_cur = row_new_q ? a_rdata : a_hold;

  always_ff @(posedge clk) begin
    if (issue_q) a_hold <= a_cur;
  end

  logic signed [ACC_W-1:0] lane_re [N];
  logic signed [ACC_W-1:0] lane_im [N];

  for (genvar k = 0; k < N; k++) begin : g_lane
    cmm_cmul_lane #(.DW(DW), .ACC_W(ACC_W)) u_lane (
      .clk  (clk),
      .a_re (a_cur[k*EW +: DW]),
      .a_im (a_cur[k*EW+DW +: DW]),
      .b_re (b_rdata[k*EW +: DW]),
      .b_im (b_rdata[k*EW+DW +: DW]),
      .p_re (lane_re[k]),
      .p_im (lane_im[k])
    );
  end

  logic signed [ACC_W-1:0] sum_re;
  logic signed [ACC_W-1:0] sum_im;

  cmm_sum_tree #(.N(N), .W(ACC_W)) u_tree_re (
    .clk   (clk),
    .leaf  (lane_re),
    .total (sum_re)
  );

  cmm_sum_tree #(.N(N), .W(ACC_W)) u_tree_im (
    .clk   (clk),
    .leaf  (lane_im),
    .total (sum_im)
  );

  // Pad the data path up to the fixed latency; the last stage is the output register.
  cmm_delay #(.W(2*ACC_W), .D(DPAD), .RST_EN(1'b0)) u_data_dly (
    .clk  (clk),
    .rst  (rst),
    .din  ({sum_im, sum_re}),
    .dout (r_data)
  );

  // Write strobe and address travel alongside the data.
  cmm_delay #(.W(1+AW), .D(LATENCY), .RST_EN(1'b1)) u_ctl_dly (
    .clk  (clk),
    .rst  (rst),
    .din  ({issue, issue_idx}),
    .dout ({r_we, r_addr})
  );

  assign last_out = r_we && (r_addr == '1);

  // R4: writes leave in strictly ascending, gap-free address order
  p_wr_order_r4: assert property (@(posedge clk) disable iff (rst)
    (r_we && r_addr != '0) |-> ($past(r_we) && r_addr == $past(r_addr) + 1'b1));

  // R4: every burst of writes begins at address zero
  p_first_wr_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(r_we) |-> (r_addr == '0));

  // R8: completion strobe lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: completion strobe directly follows the final write
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(r_we) && $past(r_addr) == '1));

endmodule

// File: tb/sim_cplx_matmul.sv
module sim_cplx_matmul;

  localparam int N     = 16;
  localparam int DW    = 16;
  localparam int ACC_W = 38;
  localparam int IW    = 4;
  localparam int AW    = 8;
  localparam int EW    = 2 * DW;
  localparam int WORDW = N * EW;
  localparam int LAT   = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, a_en, b_en, r_we;
  logic [IW-1:0] a_addr, b_addr;
  logic [AW-1:0] r_addr;
  logic [2*ACC_W-1:0] r_data;
  logic [WORDW-1:0] a_rdata, b_rdata;

  always #10 clk = ~clk;

  cplx_matmul u0 (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .a_en(a_en), .a_addr(a_addr), .a_rdata(a_rdata),
    .b_en(b_en), .b_addr(b_addr), .b_rdata(b_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_data(r_data)
  );

  // Memory models with one cycle of read latency.
  logic [WORDW-1:0] amem [N];
  logic [WORDW-1:0] bmem [N];
  always @(posedge clk) begin
    if (a_en) a_rdata <= amem[a_addr];
    if (b_en) b_rdata <= bmem[b_addr];
  end

  typedef struct {
    int     addr;
    longint re;
    longint im;
    string  tag;
  } exp_t;
  exp_t sb[$];

  int ar [N][N];
  int ai [N][N];
  int br [N][N];
  int bi [N][N];

  int total = 0;
  int bad   = 0;
  int cyc = 0;
  int a_cnt, b_cnt, wr_cnt, done_cnt;
  int rd_cyc, wr_cyc, last_wr_cyc, done_cyc;
  bit rd_seen, wr_seen;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  // Driver: fill operands, pack memory words, push the expected results.
  task automatic load_case(input int kind);
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < N; k++) begin
        case (kind)
          0: begin
            ar[i][k] = i*3 + k - 7;  ai[i][k] = k - 2*i;
            br[i][k] = 2*i - k + 1;  bi[i][k] = i*k - 20;
          end
          1: begin
            ar[i][k] = rnd16(); ai[i][k] = rnd16();
            br[i][k] = rnd16(); bi[i][k] = rnd16();
          end
          2: begin
            ar[i][k] = -32768; ai[i][k] = -32768;
            br[i][k] = -32768; bi[i][k] = 32767;
          end
          default: begin
            ar[i][k] = -32768; ai[i][k] = -32768;
            br[i][k] = -32768; bi[i][k] = -32768;
          end
        endcase
      end
    end
    for (int r = 0; r < N; r++) begin
      for (int k = 0; k < N; k++) begin
        amem[r][k*EW +: DW]    = ar[r][k][DW-1:0];
        amem[r][k*EW+DW +: DW] = ai[r][k][DW-1:0];
        bmem[r][k*EW +: DW]    = br[k][r][DW-1:0];
        bmem[r][k*EW+DW +: DW] = bi[k][r][DW-1:0];
      end
    end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        exp_t e;
        e.addr = i*N + j;
        e.re = 0;
        e.im = 0;
        for (int k = 0; k < N; k++) begin
          e.re += longint'(ar[i][k]) * br[k][j] - longint'(ai[i][k]) * bi[k][j];
          e.im += longint'(ar[i][k]) * bi[k][j] + longint'(ai[i][k]) * br[k][j];
        end
        e.tag = (kind >= 2) ? "R3" : "R1 R2";
        sb.push_back(e);
      end
    end
  endtask

  // Monitor: counts reads, checks read order, pops and compares results.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (a_en) begin
        chk(a_addr == IW'(a_cnt), "R6", "row read index", a_addr, a_cnt);
        chk(b_en && b_addr == 0, "R6", "row read aligned to column 0", b_addr, 0);
        a_cnt++;
      end
      if (b_en) begin
        chk(b_addr == IW'(b_cnt % N), "R6", "column read index", b_addr, b_cnt % N);
        if (!rd_seen) begin rd_seen = 1; rd_cyc = cyc; end
        b_cnt++;
      end
      if (r_we) begin
        longint got_re, got_im;
        got_re = $signed(r_data[ACC_W-1:0]);
        got_im = $signed(r_data[2*ACC_W-1:ACC_W]);
        if (!wr_seen) begin wr_seen = 1; wr_cyc = cyc; end
        last_wr_cyc = cyc;
        wr_cnt++;
        if (sb.size() == 0) begin
          chk(1'b0, "R4", "write with nothing expected", r_addr, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(r_addr == AW'(e.addr), "R4", "write address", r_addr, e.addr);
          chk(got_re == e.re, e.tag, "real part", got_re, e.re);
          chk(got_im == e.im, e.tag, "imag part", got_im, e.im);
        end
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic launch(input int kind);
    load_case(kind);
    a_cnt = 0; b_cnt = 0; wr_cnt = 0; done_cnt = 0;
    rd_seen = 0; wr_seen = 0;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic finish_case(input bit quiet);
    do step(); while (!done);
    chk(wr_cnt == N*N, "R4", "write count", wr_cnt, N*N);
    chk(a_cnt == N, "R6", "row reads", a_cnt, N);
    chk(b_cnt == N*N, "R6", "column reads", b_cnt, N*N);
    chk(wr_cyc - rd_cyc == LAT, "R5", "first read to first write", wr_cyc - rd_cyc, LAT);
    chk(sb.size() == 0, "R1", "results left unmatched", sb.size(), 0);
    chk(done_cyc - last_wr_cyc == 1, "R8", "done after last write", done_cyc - last_wr_cyc, 1);
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    if (quiet) begin
      step();
      chk(done == 1'b0, "R8", "done width", done, 0);
      repeat (20) step();
      chk(wr_cnt == N*N, "R7", "no writes after finish", wr_cnt, N*N);
      chk(b_cnt == N*N, "R7", "no reads after finish", b_cnt, N*N);
      chk(done_cnt == 1, "R7", "no further done", done_cnt, 1);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) step();
    chk(!a_en && !b_en && !r_we && !done, "R9", "outputs quiet in reset",
        {a_en, b_en, r_we, done}, 0);
    rst = 1'b0;
    repeat (5) step();
    chk(!a_en && !b_en && !r_we && !done, "R9", "outputs quiet before start",
        {a_en, b_en, r_we, done}, 0);

    // small mixed-sign values
    launch(0);
    finish_case(1'b1);

    // full-range pseudo-random values, with a start pulse in mid-run (R7)
    launch(1);
    repeat (40) step();
    start = 1'b1;
    step();
    start = 1'b0;
    finish_case(1'b1);

    // extreme real sum, then extreme imaginary sum started in the done cycle (R8)
    launch(2);
    finish_case(1'b0);
    launch(3);
    finish_case(1'b1);

    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

endmodule